// File: doc/BRIEF.md
# Single-Bus Multicycle Datapath

This block is the 32-bit datapath of a multicycle load/store processor in which every transfer between state elements crosses a single shared bus. In each cycle one source may place a word on the bus: the register read port, the memory read data, the ALU result or the immediate extender. Any number of sinks may capture it at the next rising clock edge: operand latches A and B, the memory address register, the instruction register, the register file, or memory (as write data). The register file holds 33 words. Entries 0 to 31 are the general registers, and entry 32 is the program counter.

An external sequencer drives a flat 19-bit control word each cycle. The datapath returns two status signals to it: whether latch A is zero, and whether memory is busy. It also returns the opcode field of the held instruction. Memory is external and slow. The datapath presents the address from the memory address register and uses the bus as write data. The memory asserts busy while an access is in progress. Busy is the only back-pressure: while it is high, the sequencer holds its request and retries, and read data on the bus is not meaningful. Memory is byte-addressed with word-aligned accesses. The datapath forwards the full 32-bit byte address, and its low two bits carry no meaning for word transfers.

Control word fields, by bit position:
- 18: load IR
- 17: load A
- 16: load B
- 15: load MA
- 14: register write
- 13: memory write
- 12: drive register
- 11: drive memory
- 10: drive ALU
- 9: drive immediate
- 8:6: register select
- 5:4: immediate select
- 3:0: ALU function

Top module: `sbus_datapath`

## Requirements
- R1: After reset, latches A, B, MA and IR and every register-file entry hold zero. With no driver active, `bus_o` is 0, `zero_o` is 1 and `opcode_o` is 0.
- R2: `bus_o` carries the value of the single active source: register read (bit 12), `mem_rdata_i` (bit 11), ALU result (bit 10) or immediate (bit 9). With no source active it is 0. At most one drive bit may be set in any cycle. `mem_wdata_o` always equals `bus_o`.
- R3: Register select codes are 0=rs (IR[25:21]), 1=rt (IR[20:16]), 2=rd (IR[15:11]), 3=program counter (entry 32), 4=link (entry 31), and 5–7 = entry 0. Entry 0 always reads zero, and writes to it are discarded.
- R4: A, B, MA and IR capture `bus_o` at the rising edge when their load bit is set. When it is clear, they hold their value. `mem_addr_o` shows MA.
- R5: Immediate select codes: 0 = IR[15:0] sign-extended; 1 = IR[15:0] zero-extended; 2 = IR[15:0] sign-extended and shifted left by 2; 3 = the whole IR.
- R6: ALU function codes: 0 A+B, 1 A−B, 2 A&B, 3 A|B, 4 A^B, 5 signed A<B as 1/0, 6 B, 7 A+4, and 9–15 give 0.
- R7: ALU function 8 gives the jump target {A[31:28], B[25:0], 2'b00}.
- R8: `zero_o` is 1 exactly when latch A holds zero. It reflects a new A value in the cycle after A is loaded.
- R9: `busy_o` follows `mem_busy_i` in the same cycle. `mem_rd_o` equals the memory-drive bit and `mem_wr_o` equals the memory-write bit. `opcode_o` is IR[31:26].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_i | input | 19 | Control word (fields above) |
| mem_rdata_i | input | 32 | Read data from memory |
| mem_busy_i | input | 1 | Memory access in progress |
| bus_o | output | 32 | Current bus value |
| zero_o | output | 1 | Latch A equals zero |
| busy_o | output | 1 | Memory busy status to sequencer |
| opcode_o | output | 6 | IR[31:26] |
| mem_addr_o | output | 32 | Byte address from MA |
| mem_wdata_o | output | 32 | Write data (the bus) |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |

## Verification
A corrupted register entry, latch or select decode shows up on `bus_o` in the first cycle that source drives the bus. It shows up on `zero_o` or `mem_addr_o` one cycle after a load. Because the bus is observable, every latched value becomes visible once it is driven back out. The reference model therefore checks the bus, status and memory pins on every cycle, and a fault is caught within a few cycles of the microstep that exposes it.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int XLEN     = 32;
  localparam int NGPR     = 32;
  localparam int NENT     = NGPR + 1;
  localparam int IDXW     = $clog2(NENT);
  localparam int PC_IDX   = NGPR;
  localparam int LINK_IDX = NGPR - 1;

  typedef enum logic [2:0] {
    SEL_RS = 3'd0, SEL_RT = 3'd1, SEL_RD = 3'd2, SEL_PC = 3'd3, SEL_LINK = 3'd4
  } rsel_e;

  typedef enum logic [1:0] {
    IMM_SX = 2'd0, IMM_ZX = 2'd1, IMM_BR = 2'd2, IMM_IR = 2'd3
  } isel_e;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0, FN_SUB = 4'd1, FN_AND = 4'd2, FN_OR = 4'd3, FN_XOR = 4'd4,
    FN_SLT = 4'd5, FN_PASSB = 4'd6, FN_INC4 = 4'd7, FN_JTGT = 4'd8
  } afn_e;

  typedef struct packed {
    logic       ld_ir;
    logic       ld_a;
    logic       ld_b;
    logic       ld_ma;
    logic       reg_wr;
    logic       mem_wr;
    logic       drv_reg;
    logic       drv_mem;
    logic       drv_alu;
    logic       drv_imm;
    logic [2:0] reg_sel;
    logic [1:0] imm_sel;
    logic [3:0] alu_fn;
  } ctl_t;

  localparam int CTLW = $bits(ctl_t);
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W    = 32,
  parameter int N    = 33,
  localparam int IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ent [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign ent[i] = '0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n)                          ent[i] <= '0;
        else if (we && (int'(idx) == i))     ent[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(idx) < N) rdata = ent[idx];
  end
endmodule

// File: rtl/sbus_immext.sv
module sbus_immext #(
  parameter int W = 32
) (
  input  logic [W-1:0] ir,
  input  logic [1:0]   sel,
  output logic [W-1:0] imm
);
  import sbus_pkg::*;
  localparam int HW = 16;

  logic [W-1:0] sx;
  assign sx = {{(W-HW){ir[HW-1]}}, ir[HW-1:0]};

  always_comb begin
    unique case (isel_e'(sel))
      IMM_SX:  imm = sx;
      IMM_ZX:  imm = {{(W-HW){1'b0}}, ir[HW-1:0]};
      IMM_BR:  imm = {sx[W-3:0], 2'b00};
      IMM_IR:  imm = ir;
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  output logic [W-1:0] y
);
  import sbus_pkg::*;
  localparam int TGT = 26;

  always_comb begin
    case (fn)
      FN_ADD:   y = a + b;
      FN_SUB:   y = a - b;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_XOR:   y = a ^ b;
      FN_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      FN_PASSB: y = b;
      FN_INC4:  y = a + W'(4);
      FN_JTGT:  y = {a[W-1:TGT+2], b[TGT-1:0], 2'b00};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTLW-1:0]  ctl_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_busy_i,
  output logic [XLEN-1:0]  bus_o,
  output logic             zero_o,
  output logic             busy_o,
  output logic [5:0]       opcode_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o
);
  ctl_t            c;
  logic [XLEN-1:0] a_q, b_q, ma_q, ir_q;
  logic [XLEN-1:0] rf_rd, alu_y, imm_v;
  logic [IDXW-1:0] rd_idx;

  assign c = ctl_t'(ctl_i);

  always_comb begin
    case (c.reg_sel)
      SEL_RS:   rd_idx = IDXW'(ir_q[25:21]);
      SEL_RT:   rd_idx = IDXW'(ir_q[20:16]);
      SEL_RD:   rd_idx = IDXW'(ir_q[15:11]);
      SEL_PC:   rd_idx = IDXW'(PC_IDX);
      SEL_LINK: rd_idx = IDXW'(LINK_IDX);
      default:  rd_idx = '0;
    endcase
  end

  sbus_regfile #(.W(XLEN), .N(NENT)) u_rf (
    .clk(clk), .rst_n(rst_n), .idx(rd_idx), .we(c.reg_wr),
    .wdata(bus_o), .rdata(rf_rd)
  );

  sbus_immext #(.W(XLEN)) u_imm (.ir(ir_q), .sel(c.imm_sel), .imm(imm_v));

  sbus_alu #(.W(XLEN)) u_alu (.a(a_q), .b(b_q), .fn(c.alu_fn), .y(alu_y));

  always_comb begin
    if (c.drv_reg)      bus_o = rf_rd;
    else if (c.drv_mem) bus_o = mem_rdata_i;
    else if (c.drv_alu) bus_o = alu_y;
    else if (c.drv_imm) bus_o = imm_v;
    else                bus_o = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
      ir_q <= '0;
    end else begin
      if (c.ld_a)  a_q  <= bus_o;
      if (c.ld_b)  b_q  <= bus_o;
      if (c.ld_ma) ma_q <= bus_o;
      if (c.ld_ir) ir_q <= bus_o;
    end
  end

  assign zero_o      = (a_q == '0);
  assign busy_o      = mem_busy_i;
  assign opcode_o    = ir_q[31:26];
  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = bus_o;
  assign mem_rd_o    = c.drv_mem;
  assign mem_wr_o    = c.mem_wr;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk
  import sbus_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CTLW-1:0]  ctl_i,
  input logic [XLEN-1:0]  bus_o,
  input logic             zero_o,
  input logic [5:0]       opcode_o,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic [XLEN-1:0]  a_q,
  input logic [IDXW-1:0]  rd_idx
);
  ctl_t c;
  assign c = ctl_t'(ctl_i);

  // R2
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({c.drv_reg, c.drv_mem, c.drv_alu, c.drv_imm}) <= 1);

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(c.drv_reg | c.drv_mem | c.drv_alu | c.drv_imm) |-> bus_o == '0);

  // R3
  reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c.drv_reg && rd_idx == '0) |-> bus_o == '0);

  // R4
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c.ld_a |=> $stable(a_q));

  // R4
  ma_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c.ld_ma |=> mem_addr_o == $past(bus_o));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c.ld_a |=> zero_o == ($past(bus_o) == '0));

  // R9
  opcode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c.ld_ir |=> opcode_o == $past(bus_o[31:26]));
endmodule

bind sbus_datapath sbus_datapath_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .bus_o(bus_o), .zero_o(zero_o),
  .opcode_o(opcode_o), .mem_addr_o(mem_addr_o), .a_q(a_q), .rd_idx(rd_idx)
);

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [18:0] L_IR = 19'b1 << 18;
  localparam logic [18:0] L_A  = 19'b1 << 17;
  localparam logic [18:0] L_B  = 19'b1 << 16;
  localparam logic [18:0] L_MA = 19'b1 << 15;
  localparam logic [18:0] W_RG = 19'b1 << 14;
  localparam logic [18:0] W_MM = 19'b1 << 13;
  localparam logic [18:0] D_RG = 19'b1 << 12;
  localparam logic [18:0] D_MM = 19'b1 << 11;
  localparam logic [18:0] D_AL = 19'b1 << 10;
  localparam logic [18:0] D_IM = 19'b1 << 9;
  function automatic logic [18:0] rs(input int v); return 19'(v) << 6; endfunction
  function automatic logic [18:0] is(input int v); return 19'(v) << 4; endfunction
  function automatic logic [18:0] fn(input int v); return 19'(v); endfunction

  logic        clk = 0, rst_n = 0;
  logic [18:0] ctl = '0;
  logic        mbusy = 0;
  logic [31:0] mrdata;
  logic [31:0] bus, maddr, mwdata;
  logic        zero, busy, mrd, mwr;
  logic [5:0]  opc;

  logic [31:0] mem_m [64];
  logic [31:0] rf_m [33];
  logic [31:0] a_m, b_m, ma_m, ir_m;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mrdata = mem_m[maddr[7:2]];

  sbus_datapath uut (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .mem_rdata_i(mrdata), .mem_busy_i(mbusy),
    .bus_o(bus), .zero_o(zero), .busy_o(busy), .opcode_o(opc), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rd_o(mrd), .mem_wr_o(mwr)
  );

  function automatic int m_idx(input logic [2:0] s);
    case (s)
      3'd0: return int'(ir_m[25:21]);
      3'd1: return int'(ir_m[20:16]);
      3'd2: return int'(ir_m[15:11]);
      3'd3: return 32;
      3'd4: return 31;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_imm(input logic [1:0] s);
    logic [31:0] sx;
    sx = {{16{ir_m[15]}}, ir_m[15:0]};
    case (s)
      2'd0: return sx;
      2'd1: return {16'h0, ir_m[15:0]};
      2'd2: return sx * 4;
      default: return ir_m;
    endcase
  endfunction

  function automatic logic [31:0] m_alu(input logic [3:0] f);
    case (f)
      4'd0: return a_m + b_m;
      4'd1: return a_m - b_m;
      4'd2: return a_m & b_m;
      4'd3: return a_m | b_m;
      4'd4: return a_m ^ b_m;
      4'd5: return ($signed(a_m) < $signed(b_m)) ? 32'd1 : 32'd0;
      4'd6: return b_m;
      4'd7: return a_m + 32'd4;
      4'd8: return {a_m[31:28], b_m[25:0], 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] m_bus(input logic [18:0] c);
    if (c[12]) return rf_m[m_idx(c[8:6])];
    if (c[11]) return mem_m[ma_m[7:2]];
    if (c[10]) return m_alu(c[3:0]);
    if (c[9])  return m_imm(c[5:4]);
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic uop(input logic [18:0] c, input logic bz, input string tag);
    logic [31:0] eb;
    int wi;
    @(negedge clk);
    ctl = c; mbusy = bz;
    #1;
    eb = m_bus(c);
    chk(tag, "bus", bus, eb);
    chk("R2", "wdata", mwdata, eb);
    chk("R8", "zero", 32'(zero), 32'(a_m == 0));
    chk("R4", "maddr", maddr, ma_m);
    chk("R9", "status", {opc, busy, mrd, mwr}, {ir_m[31:26], bz, c[11], c[13]});
    @(posedge clk);
    wi = m_idx(c[8:6]);
    if (c[14] && wi != 0) rf_m[wi] = eb;
    if (c[13] && !bz) mem_m[ma_m[7:2]] = eb;
    if (c[17]) a_m = eb;
    if (c[16]) b_m = eb;
    if (c[15]) ma_m = eb;
    if (c[18]) ir_m = eb;
  endtask

  task automatic fetch();
    uop(D_RG | L_MA | rs(3), 0, "R3");
    uop(D_MM | L_IR, 1, "R9");
    uop(D_MM | L_IR, 1, "R9");
    uop(D_MM | L_IR, 0, "R2");
    uop(D_RG | L_A | rs(3), 0, "R4");
    uop(D_AL | W_RG | rs(3) | fn(7), 0, "R6");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = 32'h0;
    for (int i = 0; i < 33; i++) rf_m[i] = 32'h0;
    a_m = 0; b_m = 0; ma_m = 0; ir_m = 0;
    mem_m[0] = {6'h08, 5'd0, 5'd5, 16'hFFFC};
    mem_m[1] = {6'h23, 5'd5, 5'd6, 5'd9, 11'h0A5};
    mem_m[2] = {6'h03, 26'h1ABCDEF};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state: idle bus, zero flag, opcode, and register reads
    uop('0, 0, "R1");
    uop(D_RG | rs(3), 0, "R1");
    uop(D_RG | rs(4), 0, "R1");
    uop(D_RG | rs(1), 0, "R1");

    // instruction word 0
    fetch();
    uop(D_RG | L_A | rs(0), 0, "R8");
    uop(D_IM | L_B | is(0), 0, "R5");
    uop(D_AL | W_RG | rs(1) | fn(0), 0, "R6");
    uop(D_RG | L_A | rs(1), 0, "R8");
    uop(D_IM | L_B | is(1), 0, "R5");
    uop(D_AL | W_RG | rs(2) | fn(1), 0, "R6");
    uop(D_IM | L_B | is(2), 0, "R5");
    uop(D_AL | W_RG | rs(0) | fn(3), 0, "R3");
    uop(D_RG | rs(0), 0, "R3");
    uop(D_RG | rs(2), 0, "R3");

    // instruction word 1
    fetch();
    uop(D_RG | L_A | rs(0), 0, "R3");
    uop(D_RG | L_B | rs(4), 0, "R3");
    uop(D_AL | W_RG | rs(1) | fn(3), 0, "R6");
    uop(D_AL | W_RG | rs(2) | fn(4), 0, "R6");
    uop(D_AL | fn(2), 0, "R6");
    uop(D_AL | W_RG | rs(1) | fn(5), 0, "R6");
    uop(D_RG | L_A | rs(4), 0, "R4");
    uop(D_RG | L_B | rs(0), 0, "R4");
    uop(D_AL | W_RG | rs(1) | fn(5), 0, "R6");
    uop(D_AL | fn(6), 0, "R6");
    uop(D_AL | fn(12), 0, "R6");
    uop(D_IM | L_B | is(0), 0, "R5");
    uop(D_IM | is(2), 0, "R5");
    uop(D_RG | L_MA | rs(2), 0, "R4");
    uop(D_RG | W_MM | rs(1), 1, "R9");
    uop(D_RG | W_MM | rs(1), 0, "R9");
    uop(D_MM | L_A, 0, "R2");
    uop('0, 0, "R2");
    uop(D_RG | rs(6), 0, "R3");

    // instruction word 2: jump target and link
    uop(D_RG | L_MA | rs(3), 0, "R3");
    uop(D_MM | L_IR, 0, "R9");
    uop(D_RG | L_A | rs(3), 0, "R4");
    uop(D_IM | L_B | is(3), 0, "R5");
    uop(D_AL | W_RG | rs(3) | fn(8), 0, "R7");
    uop(D_RG | rs(3), 0, "R7");
    uop(D_RG | L_B | rs(3), 0, "R3");
    uop(D_AL | W_RG | rs(4) | fn(6), 0, "R3");
    uop(D_RG | rs(4), 0, "R3");
    uop('0, 1, "R9");
    uop('0, 0, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule